// File: doc/BRIEF.md
# Light-Sleep Clock Enable Controller

This block decides when a small processor subsystem may stop its core clock, and when that clock comes back. The core raises a one-cycle wait-for-interrupt strobe. Light sleep starts only if both mode bits are clear: the deep-sleep select and the deep-power-down enable. There must also be no enabled interrupt already pending. If either mode bit is set, the request is refused and a sticky flag records the refusal. Deeper modes are not modelled.

Clock gating appears as registered enable outputs rather than as gated clock nets. There is one enable for the core, one per peripheral, and a one-hot enable that selects among three oscillator sources. Light sleep only drops the core enable. Peripheral enables follow their mask bits whether the core sleeps or not, so a clocked peripheral can raise the interrupt that wakes the core. A small write/read register port holds the following state, and all of it survives sleep:

- the mode bits
- the peripheral mask
- the interrupt enable mask
- the oscillator select
- a status word

Top module: `lsleep_ctrl`

## Requirements
- R1: After reset, `core_clk_en` is 1, `periph_clk_en` is all ones, `osc_clk_en` is 3'b001 (internal RC), `sleeping` is 0, and every register reads 0 except the peripheral mask, which reads 0xFF.
- R2: A `wfi_req` in active mode, with mode register (address 0) bit0 (deep-sleep select) and bit1 (deep-power-down enable) both 0 and no pending enabled interrupt, clears `core_clk_en` and sets `sleeping` at the next clock edge.
- R3: A `wfi_req` in active mode with either mode bit set leaves `core_clk_en` at 1. At the next edge it sets status (address 4) bit1. That bit holds until a write to address 4 with bit1 = 1 clears it.
- R4: A `wfi_req` in active mode with both mode bits clear, made while some `irq_in` bit whose enable bit (address 3) is 1 is already high, leaves the core active with no gating.
- R5: While sleeping, `core_clk_en` returns to 1 at the first edge where any `irq_in` bit with its enable bit set is high. Interrupts whose enable bit is clear leave the core asleep. Reset also wakes the core.
- R6: `periph_clk_en` follows the peripheral mask (address 1) one cycle after a write, and does not change on sleep entry or exit.
- R7: The oscillator select (address 2, bits[1:0]) maps 0 to internal RC, 1 to system oscillator and 2 to watchdog oscillator. These drive `osc_clk_en` bit 0, 1 and 2 one cycle after the write. A write of 3 is ignored, and the select is unchanged by sleep.
- R8: Register contents are kept through sleep and wake. Status bit0 reads the current mode (1 = sleeping).
- R9: A `wfi_req` arriving while already sleeping has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wfi_req | input | 1 | Wait-for-interrupt strobe from the core |
| irq_in | input | 8 | Interrupt request lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from address) |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 8 | Per-peripheral clock enables |
| osc_clk_en | output | 3 | One-hot oscillator source enable |
| sleeping | output | 1 | High while in light sleep |

## Verification
The bench tries the sleep request against every combination of the two mode bits, against pending interrupts that are enabled and ones that are not, and against both together.

- A masked pending interrupt still allows sleep, while an enabled one blocks it. This separates masked requests from enabled ones.
- A set mode bit wins over a pending interrupt and produces a refusal. This separates a refusal from an interrupt block.

Directed cases then check the following:

- wake through masked and unmasked lines
- a repeated request while asleep
- every oscillator encoding, including the illegal one
- that the peripheral enables and register contents are unchanged across a sleep and wake cycle

// File: rtl/lsleep_pkg.sv
package lsleep_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_PMASK = 3'd1;
  localparam logic [ADDR_W-1:0] A_OSC   = 3'd2;
  localparam logic [ADDR_W-1:0] A_IRQEN = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;

  localparam int OSC_N = 3;
  typedef enum logic [1:0] {
    OSC_IRC  = 2'd0,
    OSC_SYS  = 2'd1,
    OSC_WDOG = 2'd2
  } osc_sel_t;

  typedef enum logic {
    ST_ACTIVE = 1'b0,
    ST_SLEEP  = 1'b1
  } pmode_t;
endpackage

// File: rtl/lsleep_regs.sv
module lsleep_regs
  import lsleep_pkg::*;
#(
  parameter int NPERIPH = 8,
  parameter int NIRQ    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               refuse_evt,
  input  logic               sleeping,
  output logic               deep_sel,
  output logic               dpd_en,
  output logic [NPERIPH-1:0] pmask,
  output logic [NIRQ-1:0]    irq_mask,
  output osc_sel_t           osc_sel,
  output logic               refused,
  output logic [DATA_W-1:0]  rdata
);
  localparam logic [NPERIPH-1:0] PMASK_RST = '1;

  logic clr_refused;
  assign clr_refused = we && (addr == A_STAT) && wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      deep_sel <= 1'b0;
      dpd_en   <= 1'b0;
      pmask    <= PMASK_RST;
      irq_mask <= '0;
      osc_sel  <= OSC_IRC;
      refused  <= 1'b0;
    end else begin
      if (refuse_evt)       refused <= 1'b1;
      else if (clr_refused) refused <= 1'b0;
      if (we) begin
        unique case (addr)
          A_MODE: begin
            deep_sel <= wdata[0];
            dpd_en   <= wdata[1];
          end
          A_PMASK: pmask    <= wdata[NPERIPH-1:0];
          A_IRQEN: irq_mask <= wdata[NIRQ-1:0];
          A_OSC: begin
            if (wdata[1:0] != 2'd3) osc_sel <= osc_sel_t'(wdata[1:0]);
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (addr)
      A_MODE:  rdata = DATA_W'({dpd_en, deep_sel});
      A_PMASK: rdata = DATA_W'(pmask);
      A_OSC:   rdata = DATA_W'(osc_sel);
      A_IRQEN: rdata = DATA_W'(irq_mask);
      A_STAT:  rdata = DATA_W'({refused, sleeping});
      default: rdata = '0;
    endcase
  end

  // R7
  osc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_sel != 2'd3);

  // R3
  refused_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refused && !clr_refused) |=> refused);
endmodule

// File: rtl/lsleep_fsm.sv
module lsleep_fsm
  import lsleep_pkg::*;
#(
  parameter int NIRQ = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wfi_req,
  input  logic [NIRQ-1:0] irq_in,
  input  logic [NIRQ-1:0] irq_mask,
  input  logic            deep_sel,
  input  logic            dpd_en,
  output logic            core_en,
  output logic            sleeping,
  output logic            refuse_evt
);
  pmode_t state_q, state_d;
  logic   wake_hit, mode_block;

  assign wake_hit   = |(irq_in & irq_mask);
  assign mode_block = deep_sel | dpd_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACTIVE: if (wfi_req && !mode_block && !wake_hit) state_d = ST_SLEEP;
      ST_SLEEP:  if (wake_hit) state_d = ST_ACTIVE;
      default:   state_d = ST_ACTIVE;
    endcase
  end

  assign refuse_evt = (state_q == ST_ACTIVE) && wfi_req && mode_block;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_ACTIVE;
      core_en <= 1'b1;
    end else begin
      state_q <= state_d;
      core_en <= (state_d == ST_ACTIVE);
    end
  end

  assign sleeping = (state_q == ST_SLEEP);

  // R2
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleeping && wfi_req && !mode_block && !wake_hit) |=> (!core_en && sleeping));

  // R3
  refuse_no_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleeping && wfi_req && mode_block) |=> core_en);

  // R4
  pending_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleeping && wake_hit) |=> core_en);

  // R5
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && wake_hit) |=> (core_en && !sleeping));

  // R9
  wfi_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && !wake_hit) |=> (sleeping && !core_en));
endmodule

// File: rtl/lsleep_enables.sv
module lsleep_enables
  import lsleep_pkg::*;
#(
  parameter int NPERIPH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPERIPH-1:0] pmask,
  input  osc_sel_t           osc_sel,
  output logic [NPERIPH-1:0] periph_en,
  output logic [OSC_N-1:0]   osc_en
);
  for (genvar g = 0; g < OSC_N; g++) begin : g_osc
    always_ff @(posedge clk) begin
      if (!rst_n) osc_en[g] <= (g == 0);
      else        osc_en[g] <= (osc_sel == osc_sel_t'(g));
    end
  end

  for (genvar p = 0; p < NPERIPH; p++) begin : g_per
    always_ff @(posedge clk) begin
      if (!rst_n) periph_en[p] <= 1'b1;
      else        periph_en[p] <= pmask[p];
    end
  end

  // R7
  osc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(osc_en) == 1);
endmodule

// File: rtl/lsleep_ctrl.sv
module lsleep_ctrl
  import lsleep_pkg::*;
#(
  parameter int NPERIPH = 8,
  parameter int NIRQ    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wfi_req,
  input  logic [NIRQ-1:0]    irq_in,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               core_clk_en,
  output logic [NPERIPH-1:0] periph_clk_en,
  output logic [OSC_N-1:0]   osc_clk_en,
  output logic               sleeping
);
  logic               deep_sel, dpd_en, refused, refuse_evt;
  logic [NPERIPH-1:0] pmask;
  logic [NIRQ-1:0]    irq_mask;
  osc_sel_t           osc_sel;

  lsleep_regs #(.NPERIPH(NPERIPH), .NIRQ(NIRQ)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .refuse_evt(refuse_evt), .sleeping(sleeping), .deep_sel(deep_sel),
    .dpd_en(dpd_en), .pmask(pmask), .irq_mask(irq_mask), .osc_sel(osc_sel),
    .refused(refused), .rdata(reg_rdata)
  );

  lsleep_fsm #(.NIRQ(NIRQ)) fsm_i (
    .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .irq_in(irq_in),
    .irq_mask(irq_mask), .deep_sel(deep_sel), .dpd_en(dpd_en),
    .core_en(core_clk_en), .sleeping(sleeping), .refuse_evt(refuse_evt)
  );

  lsleep_enables #(.NPERIPH(NPERIPH)) en_i (
    .clk(clk), .rst_n(rst_n), .pmask(pmask), .osc_sel(osc_sel),
    .periph_en(periph_clk_en), .osc_en(osc_clk_en)
  );

  // R6
  periph_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && !$past(reg_we)) |=> $stable(periph_clk_en));

  // R3
  refused_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_evt |=> refused);
endmodule

// File: tb/lsleep_ctrl_tb_top.sv
module lsleep_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wfi_req = 1'b0;
  logic [7:0] irq_in = '0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       core_clk_en;
  logic [7:0] periph_clk_en;
  logic [2:0] osc_clk_en;
  logic       sleeping;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  lsleep_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .irq_in(irq_in),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .core_clk_en(core_clk_en),
    .periph_clk_en(periph_clk_en), .osc_clk_en(osc_clk_en), .sleeping(sleeping)
  );

  // {mode[1:0], irq_en[7:0], pending[7:0], exp_sleep, exp_refused}
  localparam int NV = 9;
  localparam logic [19:0] VEC [NV] = '{
    {2'd0, 8'h00, 8'h00, 1'b1, 1'b0},
    {2'd0, 8'h01, 8'h02, 1'b1, 1'b0},
    {2'd0, 8'h01, 8'h01, 1'b0, 1'b0},
    {2'd0, 8'h80, 8'hFF, 1'b0, 1'b0},
    {2'd1, 8'h00, 8'h00, 1'b0, 1'b1},
    {2'd2, 8'h00, 8'h00, 1'b0, 1'b1},
    {2'd3, 8'hFF, 8'h00, 1'b0, 1'b1},
    {2'd1, 8'h01, 8'h01, 1'b0, 1'b1},
    {2'd0, 8'hF0, 8'h0F, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_wfi();
    @(negedge clk);
    wfi_req = 1'b1;
    @(negedge clk);
    wfi_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 core_en", core_clk_en, 1);
    chk("R1 periph", periph_clk_en, 8'hFF);
    chk("R1 osc", osc_clk_en, 3'b001);
    chk("R1 sleeping", sleeping, 0);
    rd(3'd0, r); chk("R1 mode reg", r, 0);
    rd(3'd1, r); chk("R1 pmask reg", r, 8'hFF);
    rd(3'd3, r); chk("R1 irqen reg", r, 0);
    rd(3'd4, r); chk("R1 status", r, 0);

    // vector table: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      v = VEC[i];
      irq_in = '0;
      wr(3'd3, v[17:10]);
      wr(3'd0, {6'd0, v[19:18]});
      wr(3'd4, 8'h02);
      irq_in = v[9:2];
      pulse_wfi();
      chk($sformatf("R2/R4 vec%0d core_en", i), core_clk_en, !v[1]);
      chk($sformatf("R2 vec%0d sleeping", i), sleeping, v[1]);
      rd(3'd4, r);
      chk($sformatf("R3 vec%0d refused", i), r[1], v[0]);
      chk($sformatf("R8 vec%0d status mode", i), r[0], v[1]);
      if (v[1]) begin
        irq_in = '0;
        wr(3'd3, 8'h04);
        chk($sformatf("R5 vec%0d still asleep", i), core_clk_en, 0);
        irq_in = 8'h04;
        @(negedge clk);
        chk($sformatf("R5 vec%0d woke", i), core_clk_en, 1);
        irq_in = '0;
      end
    end

    // R3 sticky then clear
    wr(3'd0, 8'h02);
    pulse_wfi();
    @(negedge clk);
    rd(3'd4, r); chk("R3 sticky", r[1], 1);
    wr(3'd4, 8'h02);
    rd(3'd4, r); chk("R3 cleared", r[1], 0);
    wr(3'd0, 8'h00);

    // R7 oscillator select
    wr(3'd2, 8'd1); @(negedge clk);
    chk("R7 sys osc", osc_clk_en, 3'b010);
    wr(3'd2, 8'd2); @(negedge clk);
    chk("R7 wdog osc", osc_clk_en, 3'b100);
    wr(3'd2, 8'd3); @(negedge clk);
    chk("R7 code3 ignored", osc_clk_en, 3'b100);
    rd(3'd2, r); chk("R7 code3 reg", r, 8'd2);
    wr(3'd2, 8'd0); @(negedge clk);
    chk("R7 irc", osc_clk_en, 3'b001);

    // R6 / R8 / R9 / R5 masked irq while asleep
    wr(3'd1, 8'hA5); @(negedge clk);
    chk("R6 mask follows", periph_clk_en, 8'hA5);
    wr(3'd2, 8'd1);
    wr(3'd3, 8'h10);
    irq_in = '0;
    pulse_wfi();
    chk("R2 asleep", core_clk_en, 0);
    chk("R6 periph in sleep", periph_clk_en, 8'hA5);
    chk("R7 osc in sleep", osc_clk_en, 3'b010);
    pulse_wfi();
    chk("R9 wfi while asleep", sleeping, 1);
    irq_in = 8'h01;
    @(negedge clk); @(negedge clk);
    chk("R5 masked irq no wake", core_clk_en, 0);
    irq_in = 8'h10;
    @(negedge clk);
    chk("R5 enabled wake", core_clk_en, 1);
    irq_in = '0;
    chk("R6 periph after wake", periph_clk_en, 8'hA5);
    rd(3'd1, r); chk("R8 pmask kept", r, 8'hA5);
    rd(3'd3, r); chk("R8 irqen kept", r, 8'h10);
    rd(3'd2, r); chk("R8 osc kept", r, 8'd1);

    // R5 reset wakes
    pulse_wfi();
    chk("R5 asleep before reset", sleeping, 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R5 reset wakes", core_clk_en, 1);
    chk("R1 osc after reset", osc_clk_en, 3'b001);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule